// File: doc/BRIEF.md
# Boundary-Scan Output-Enable Control Slice

This block is a compact test access port for the read-data bus of a synchronous memory. It holds the 16-state TAP controller, a 3-bit instruction register, a one-bit bypass register and a short boundary register. The boundary register has one cell for each bit of the output data bus and one extra cell that carries no data. That extra cell is the bus-wide drive control: when the external-test instruction is current, its preloaded value decides whether the whole output bus drives or is released to high impedance.

In functional operation the bus data and bus enable pass straight through from the memory core. A test controller scans a drive pattern and a control bit into the boundary register with the sample/preload instruction. It then switches to the external-test instruction, and from that point the scanned values, not the core, drive the bus. The control cell comes out of reset, and out of every visit to Test-Logic-Reset, set to drive.

Top module: `bscan_oe_slice`

## Requirements
- R1: While trst_n is low the controller sits in Test-Logic-Reset, the instruction is bypass (3'b111), tdo_en is 0, the control cell's preload register is 1 and the data preload registers are 0.
- R2: Five rising tck edges with tms high bring the controller to Test-Logic-Reset from any state. The edge that enters Test-Logic-Reset also loads the bypass instruction and sets the control preload to 1.
- R3: Capture-IR loads 3'b001 into the instruction shift stage, and Shift-IR sends it out on tdo LSB first. Update-IR adopts the three bits shifted in, with the first bit in becoming bit 0.
- R4: Every code other than 3'b000 (external test) and 3'b100 (sample/preload) selects the one-bit bypass register. Bypass captures 0 and delays tdi by one shift. These codes leave the preload registers and the bus outputs untouched.
- R5: Under sample/preload or external test, Capture-DR loads the control stage with func_oe and data stage k with func_data[k]. The control stage is next to tdo, so it shifts out first, followed by data bits 0 upward. tdi enters at the data MSB stage.
- R6: Update-DR under a boundary instruction copies the shift stages into the preload registers. The preloads hold in every other state. The data preloads also hold across Test-Logic-Reset.
- R7: While external test is current, bus_oe equals the control preload (1 drive, 0 whole bus in high impedance) and bus_data equals the data preloads, and func_data and func_oe are ignored. Under any other instruction bus_oe and bus_data follow func_oe and func_data.
- R8: tms and tdi are taken on the rising edge of tck. tdo changes only after a falling edge of tck.
- R9: tdo_en is 1 exactly while the controller is in Shift-IR or Shift-DR, and it is updated on the falling edge of tck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| func_data | input | DATA_W | Read data from the memory core |
| func_oe | input | 1 | Output enable from the memory core |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Drive enable for tdo |
| bus_data | output | DATA_W | Data presented to the output pins |
| bus_oe | output | 1 | Bus drive enable, 0 means high impedance |

## Verification
The main sweep covers all 32 combinations of control bit and data pattern for a 4-bit bus. Each combination is first scanned in under sample/preload, which shows that the bus still follows the core and that the captured word comes out in the right order. It is then made live under external test, which shows that each scanned bit reaches its own pin and that the control bit alone floats or drives the bus. Each of the six reserved and bypass codes is run against a known preload, which separates a one-stage bypass path from the boundary path and shows that no update leaks through. Sixteen tms walks from different controller states, each closed by five high bits, show the return to Test-Logic-Reset and the re-preset of the control cell.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int unsigned OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_EXTEST  = 3'b000;
  localparam logic [OPC_W-1:0] OPC_SAMPLE  = 3'b100;
  localparam logic [OPC_W-1:0] OPC_BYPASS  = 3'b111;
  localparam logic [OPC_W-1:0] OPC_IR_CAPT = 3'b001;

  typedef enum logic {PATH_BYPASS, PATH_BOUNDARY} dr_path_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = m ? TS_EX1_DR   : TS_SH_DR;
      TS_SH_DR:    n = m ? TS_EX1_DR   : TS_SH_DR;
      TS_EX1_DR:   n = m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = m ? TS_EX2_DR   : TS_PAUSE_DR;
      TS_EX2_DR:   n = m ? TS_UPD_DR   : TS_SH_DR;
      TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = m ? TS_EX1_IR   : TS_SH_IR;
      TS_SH_IR:    n = m ? TS_EX1_IR   : TS_SH_IR;
      TS_EX1_IR:   n = m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = m ? TS_EX2_IR   : TS_PAUSE_IR;
      TS_EX2_IR:   n = m ? TS_UPD_IR   : TS_SH_IR;
      TS_UPD_IR:   n = m ? TS_SEL_DR   : TS_IDLE;
      default:     n = TS_RESET;
    endcase
    return n;
  endfunction

  function automatic dr_path_e path_of(input logic [OPC_W-1:0] op);
    return ((op == OPC_EXTEST) || (op == OPC_SAMPLE)) ? PATH_BOUNDARY : PATH_BYPASS;
  endfunction

  function automatic logic pins_from_preload(input logic [OPC_W-1:0] op);
    return op == OPC_EXTEST;
  endfunction

  function automatic logic is_shift(input tap_state_e s);
    return (s == TS_SH_DR) || (s == TS_SH_IR);
  endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nxt
);

  assign state_nxt = tap_next(state, tms);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= state_nxt;
  end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  tap_state_e       state,
  input  tap_state_e       state_nxt,
  input  logic             tdi,
  output logic [OPC_W-1:0] opcode,
  output logic             sh_out
);

  logic [OPC_W-1:0] sh_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q <= OPC_IR_CAPT;
    end else if (state == TS_CAP_IR) begin
      sh_q <= OPC_IR_CAPT;
    end else if (state == TS_SH_IR) begin
      sh_q <= {tdi, sh_q[OPC_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      opcode <= OPC_BYPASS;
    end else if (state_nxt == TS_RESET) begin
      opcode <= OPC_BYPASS;
    end else if (state == TS_UPD_IR) begin
      opcode <= sh_q;
    end
  end

  assign sh_out = sh_q[0];

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
  import bscan_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              tck,
  input  logic              trst_n,
  input  tap_state_e        state,
  input  tap_state_e        state_nxt,
  input  logic              sel,
  input  logic              tdi,
  input  logic [DATA_W-1:0] func_data,
  input  logic              func_oe,
  output logic              ctrl_pre,
  output logic [DATA_W-1:0] data_pre,
  output logic              sh_out,
  output logic              upd_evt
);

  localparam int unsigned LEN = DATA_W + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;
  logic           cap_evt;
  logic           shf_evt;

  assign cap_evt = sel && (state == TS_CAP_DR);
  assign shf_evt = sel && (state == TS_SH_DR);
  assign upd_evt = sel && (state == TS_UPD_DR);

  // control cell sits next to tdo
  assign sh_d[0] = cap_evt ? func_oe : (shf_evt ? sh_q[1] : sh_q[0]);

  for (genvar g = 0; g < DATA_W; g++) begin : g_cell
    logic feed;
    if (g == DATA_W - 1) begin : g_top
      assign feed = tdi;
    end else begin : g_mid
      assign feed = sh_q[g+2];
    end
    assign sh_d[g+1] = cap_evt ? func_data[g] : (shf_evt ? feed : sh_q[g+1]);
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ctrl_pre <= 1'b1;
      data_pre <= '0;
    end else if (state_nxt == TS_RESET) begin
      ctrl_pre <= 1'b1;
    end else if (upd_evt) begin
      ctrl_pre <= sh_q[0];
      data_pre <= sh_q[LEN-1:1];
    end
  end

  assign sh_out = sh_q[0];

endmodule

// File: rtl/bscan_oe_slice.sv
module bscan_oe_slice
  import bscan_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [DATA_W-1:0] func_data,
  input  logic              func_oe,
  output logic              tdo,
  output logic              tdo_en,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe
);

  tap_state_e       tap_state;
  tap_state_e       tap_state_nxt;
  logic [OPC_W-1:0] opcode;
  logic             ir_lsb;
  logic             bsr_lsb;
  logic             bsr_upd_evt;
  logic             ctrl_pre;
  logic [DATA_W-1:0] data_pre;
  dr_path_e         path;
  logic             byp_q;
  logic             tdo_q;
  logic             tdo_en_q;

  bscan_tap_fsm u_fsm (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .state     (tap_state),
    .state_nxt (tap_state_nxt)
  );

  bscan_ir u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (tap_state),
    .state_nxt (tap_state_nxt),
    .tdi       (tdi),
    .opcode    (opcode),
    .sh_out    (ir_lsb)
  );

  assign path = path_of(opcode);

  bscan_bsr #(.DATA_W(DATA_W)) u_bsr (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (tap_state),
    .state_nxt (tap_state_nxt),
    .sel       (path == PATH_BOUNDARY),
    .tdi       (tdi),
    .func_data (func_data),
    .func_oe   (func_oe),
    .ctrl_pre  (ctrl_pre),
    .data_pre  (data_pre),
    .sh_out    (bsr_lsb),
    .upd_evt   (bsr_upd_evt)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (path == PATH_BYPASS) begin
      if (tap_state == TS_CAP_DR)     byp_q <= 1'b0;
      else if (tap_state == TS_SH_DR) byp_q <= tdi;
    end
  end

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= is_shift(tap_state);
      if (tap_state == TS_SH_IR)      tdo_q <= ir_lsb;
      else if (path == PATH_BOUNDARY) tdo_q <= bsr_lsb;
      else                            tdo_q <= byp_q;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_en = tdo_en_q;

  assign bus_oe   = pins_from_preload(opcode) ? ctrl_pre : func_oe;
  assign bus_data = pins_from_preload(opcode) ? data_pre : func_data;

endmodule

// File: rtl/bscan_oe_slice_chk.sv
module bscan_oe_slice_chk
  import bscan_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input logic              tck,
  input logic              trst_n,
  input logic              tms,
  input logic              tdo,
  input logic              tdo_en,
  input tap_state_e        state,
  input tap_state_e        state_nxt,
  input logic              ctrl_pre,
  input logic [DATA_W-1:0] data_pre,
  input logic [OPC_W-1:0]  opcode,
  input logic              upd_evt
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ones_cnt <= '0;
    else if (!tms)     ones_cnt <= '0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
  end

  // R2
  tlr_reach_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt >= 3'd5) |-> (state == TS_RESET));

  // R2
  tlr_preset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_nxt == TS_RESET) |=> (ctrl_pre && (opcode == OPC_BYPASS)));

  // R6
  pre_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_evt && (state_nxt != TS_RESET)) |=> ($stable(ctrl_pre) && $stable(data_pre)));

  // R4
  rsvd_noupd_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ((state == TS_UPD_DR) && (opcode != OPC_EXTEST) && (opcode != OPC_SAMPLE))
      |=> ($stable(ctrl_pre) && $stable(data_pre)));

  // R9
  tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == ((state == TS_SH_DR) || (state == TS_SH_IR)));

  // R8
  always @(tdo) begin
    if (trst_n === 1'b1) begin
      tdo_edge_chk: assert (tck == 1'b0) else $error("tdo moved while tck high");
    end
  end

endmodule

bind bscan_oe_slice bscan_oe_slice_chk #(.DATA_W(DATA_W)) u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .tms       (tms),
  .tdo       (tdo),
  .tdo_en    (tdo_en),
  .state     (tap_state),
  .state_nxt (tap_state_nxt),
  .ctrl_pre  (ctrl_pre),
  .data_pre  (data_pre),
  .opcode    (opcode),
  .upd_evt   (bsr_upd_evt)
);

// File: tb/tb_bscan_oe_slice.sv
`timescale 1ns/1ps
module tb_bscan_oe_slice;

  localparam int W = 4;
  localparam int L = W + 3;

  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4, M_E1DR = 5,
                 M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_SHIR = 11,
                 M_E1IR = 12, M_PIR = 13, M_E2IR = 14, M_UIR = 15;

  logic         tck = 1'b0;
  logic         trst_n;
  logic         tms;
  logic         tdi;
  logic [W-1:0] func_data;
  logic         func_oe;
  logic         tdo;
  logic         tdo_en;
  logic [W-1:0] bus_data;
  logic         bus_oe;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   mstate = M_TLR;
  logic tdo_neg = 1'b0;
  bit   done = 1'b0;

  bscan_oe_slice #(.DATA_W(W)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .func_data(func_data), .func_oe(func_oe),
    .tdo(tdo), .tdo_en(tdo_en), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  always #2.5 tck = ~tck;

  function automatic int tap_nx(input int s, input logic m);
    int r;
    if (m) begin
      case (s)
        M_TLR: r = M_TLR;   M_RTI: r = M_SDR;   M_SDR: r = M_SIR;   M_CDR: r = M_E1DR;
        M_SHDR: r = M_E1DR; M_E1DR: r = M_UDR;  M_PDR: r = M_E2DR;  M_E2DR: r = M_UDR;
        M_UDR: r = M_SDR;   M_SIR: r = M_TLR;   M_CIR: r = M_E1IR;  M_SHIR: r = M_E1IR;
        M_E1IR: r = M_UIR;  M_PIR: r = M_E2IR;  M_E2IR: r = M_UIR;  default: r = M_SDR;
      endcase
    end else begin
      case (s)
        M_TLR: r = M_RTI;   M_RTI: r = M_RTI;   M_SDR: r = M_CDR;   M_CDR: r = M_SHDR;
        M_SHDR: r = M_SHDR; M_E1DR: r = M_PDR;  M_PDR: r = M_PDR;   M_E2DR: r = M_SHDR;
        M_UDR: r = M_RTI;   M_SIR: r = M_CIR;   M_CIR: r = M_SHIR;  M_SHIR: r = M_SHIR;
        M_E1IR: r = M_PIR;  M_PIR: r = M_PIR;   M_E2IR: r = M_SHIR; default: r = M_RTI;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one tck period: drive, rising edge, falling edge, sample
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck); #1;
    if (tdo_en === 1'b1) chk(tdo === tdo_neg, "R8 tdo held over rising edge", tdo, tdo_neg);
    mstate = tap_nx(mstate, m);
    @(negedge tck); #1;
    tdo_neg = tdo;
    chk(tdo_en === ((mstate == M_SHDR) || (mstate == M_SHIR)), "R9 tdo_en", tdo_en, mstate);
  endtask

  task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo_neg;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input logic [L-1:0] din, output logic [L-1:0] dout);
    logic         b_oe;
    logic [W-1:0] b_d;
    b_oe = bus_oe;
    b_d  = bus_data;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < L; i++) begin
      dout[i] = tdo_neg;
      step(i == L - 1, din[i]);
      chk((bus_oe === b_oe) && (bus_data === b_d), "R6 bus held while shifting",
          {bus_oe, bus_data}, {b_oe, b_d});
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [2:0]   cap;
    logic [L-1:0] dout;
    logic [L-1:0] din;
    logic [W-1:0] fd;
    logic         fo;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    func_data = 4'b1001; func_oe = 1'b0;
    #12;
    // R1
    chk(tdo_en === 1'b0, "R1 tdo_en in reset", tdo_en, 0);
    chk((bus_oe === func_oe) && (bus_data === func_data), "R1 bus follows core in reset",
        {bus_oe, bus_data}, {func_oe, func_data});
    @(negedge tck); #1;
    trst_n = 1'b1;
    mstate = M_TLR;
    tdo_neg = tdo;
    step(0, 0);
    ir_scan(3'b000, cap);
    chk(cap === 3'b001, "R3 captured instruction", cap, 3'b001);
    chk((bus_oe === 1'b1) && (bus_data === 4'b0000), "R1 preload values after reset",
        {bus_oe, bus_data}, 5'b10000);

    // R5 R6 R7: every control/data pattern
    for (int p = 0; p < 32; p++) begin
      fd = 4'((p * 5 + 3) % 16);
      fo = ((p % 3) == 0);
      func_data = fd; func_oe = fo;
      ir_scan(3'b100, cap);
      chk(cap === 3'b001, "R3 captured instruction", cap, 3'b001);
      chk((bus_oe === fo) && (bus_data === fd), "R7 sample keeps core on bus",
          {bus_oe, bus_data}, {fo, fd});
      din = {5'(p), 2'b10};
      dr_scan(din, dout);
      chk(dout === {2'b10, fd, fo}, "R5 capture and shift order", dout, {2'b10, fd, fo});
      ir_scan(3'b000, cap);
      chk((bus_oe === din[2]) && (bus_data === din[6:3]), "R7 extest drives preload",
          {bus_oe, bus_data}, din[6:2]);
      func_data = ~fd; func_oe = ~fo;
      #1;
      chk((bus_oe === din[2]) && (bus_data === din[6:3]), "R7 core ignored in extest",
          {bus_oe, bus_data}, din[6:2]);
    end

    // R4: bypass and reserved codes
    for (int op = 1; op < 8; op++) begin
      if (op == 4) continue;
      ir_scan(3'b100, cap);
      dr_scan({5'b10110, 2'b00}, dout);
      ir_scan(3'(op), cap);
      func_data = 4'(op); func_oe = op[0];
      #1;
      chk((bus_oe === func_oe) && (bus_data === func_data), "R4 code leaves bus to core",
          {bus_oe, bus_data}, {func_oe, func_data});
      din = 7'b1011001;
      dr_scan(din, dout);
      chk(dout === {din[L-2:0], 1'b0}, "R4 one-stage bypass", dout, {din[L-2:0], 1'b0});
      ir_scan(3'b000, cap);
      chk((bus_oe === 1'b0) && (bus_data === 4'b1011), "R4 no preload update",
          {bus_oe, bus_data}, 5'b01011);
    end

    // R2: walk to many states, then five tms highs
    for (int k = 0; k < 16; k++) begin
      ir_scan(3'b100, cap);
      dr_scan({4'b0110, 1'b0, 2'b00}, dout);
      ir_scan(3'b000, cap);
      chk(bus_oe === 1'b0, "R7 control 0 floats bus", bus_oe, 0);
      for (int j = 0; j < 4; j++) step(k[j], ~k[j]);
      for (int j = 0; j < 5; j++) step(1, 0);
      func_data = 4'(k); func_oe = k[0];
      #1;
      chk((bus_oe === func_oe) && (bus_data === func_data), "R2 reset selects bypass",
          {bus_oe, bus_data}, {func_oe, func_data});
      step(0, 0);
      ir_scan(3'b000, cap);
      chk(bus_oe === 1'b1, "R2 control preset on reset entry", bus_oe, 1);
      if (k == 0)
        chk(bus_data === 4'b0110, "R6 data preload holds across reset", bus_data, 4'b0110);
    end

    report();
  end

endmodule